// File: doc/BRIEF.md
# Sign-Magnitude Fixed-Point Add/Multiply Unit

This unit performs one arithmetic operation per accepted request on short fixed-point words held in sign-magnitude form. Each word carries a sign flag in its top bit, then an integer field and a fractional field. With the default widths that is 6 bits: one sign bit, one integer bit and four fractional bits. A word therefore spans magnitudes from 0 to 31/16 in steps of 1/16. It serves as the arithmetic core for small filters that work on normalised samples. Conversion to or from two's complement, and sequencing of the filter taps, happen outside the unit.

A request carries two operands and an operation select, and it enters through a valid/ready handshake. The result leaves through a second valid/ready handshake, registered one clock after acceptance. An addition compares the two magnitudes to decide between adding and subtracting and to choose the sign of the result. A multiplication multiplies the magnitudes and drops the extra fractional bits. Any magnitude that exceeds the format is clipped to the largest one instead of wrapping. Back-pressure rule: a result stays on the output until the consumer takes it by holding `m_ready` high. While a result is waiting with `m_ready` low, `s_ready` is low and no new request is taken. When `m_ready` is high, the unit accepts one request per clock.

Top module: `smfx_arith`

## Requirements
- R1: A word is `{sign, magnitude}`. Bit 5 is the sign (0 positive, 1 negative). Bits 4:0 are the magnitude, read as an unsigned value divided by 16: bit 4 is the integer bit and bits 3:0 are the fraction.
- R2: When the operation select is 0 (add) and the operand signs are equal, the result magnitude is the sum of the magnitudes and the result sign is the common sign.
- R3: When the operation select is 0 (add) and the signs differ, the result magnitude is the larger magnitude minus the smaller, with the sign of the operand whose magnitude is larger. Equal magnitudes give zero.
- R4: An addition whose magnitude sum exceeds 31 returns magnitude 31 (11111) and keeps the common sign.
- R5: When the operation select is 1 (multiply), the result sign is the XOR of the operand signs. The result magnitude is the 10-bit magnitude product shifted right by 4, with the dropped bits discarded.
- R6: A multiplication whose shifted product exceeds 31 returns magnitude 31 (11111).
- R7: A result with zero magnitude always carries sign 0. Negative zero never appears at the output, even when an operand is negative zero.
- R8: A request taken at a clock edge (`s_valid` and `s_ready` both high) makes `m_valid` high with its result from that same edge. With `m_ready` held high, requests are taken back to back, one per clock, and their results appear in order.
- R9: While `m_valid` is high and `m_ready` is low, `s_ready` is low, and `m_valid` and `m_data` hold their values.
- R10: During and right after reset, `m_valid` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request present |
| s_ready | output | 1 | Unit can take a request this cycle |
| s_op | input | 1 | Operation select: 0 add, 1 multiply |
| s_a | input | 6 | First operand, sign-magnitude |
| s_b | input | 6 | Second operand, sign-magnitude |
| m_valid | output | 1 | Result present |
| m_ready | input | 1 | Consumer takes the result this cycle |
| m_data | output | 6 | Result, sign-magnitude |

## Verification
A result is due exactly one clock after its request is taken, so the bench puts each expected word into a queue at the moment of acceptance. A monitor pops one entry for every cycle in which `m_valid` and `m_ready` are both high. With back-pressure off, the bench also checks that `m_valid` is already high right after the accepting edge. With back-pressure on, it checks on the cycle after a stall that the word on the output is unchanged and that `s_ready` stayed low. The add and multiply paths are each run over every pair of 6-bit operands.

// File: rtl/smfx_pkg.sv
package smfx_pkg;

  typedef enum logic {
    SMFX_ADD = 1'b0,
    SMFX_MUL = 1'b1
  } smfx_op_e;

endpackage

// File: rtl/smfx_addsub.sv
module smfx_addsub #(
  parameter int MAG_W = 5
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             r_sign,
  output logic [MAG_W-1:0] r_mag
);

  logic [MAG_W:0]   sum_w;
  logic [MAG_W-1:0] diff;
  logic             a_ge;
  logic             same;

  assign same  = (a_sign == b_sign);
  assign a_ge  = (a_mag >= b_mag);
  assign sum_w = {1'b0, a_mag} + {1'b0, b_mag};
  assign diff  = a_ge ? (a_mag - b_mag) : (b_mag - a_mag);

  always_comb begin
    if (same) begin
      r_sign = a_sign;
      r_mag  = sum_w[MAG_W] ? {MAG_W{1'b1}} : sum_w[MAG_W-1:0];
    end else begin
      r_sign = a_ge ? a_sign : b_sign;
      r_mag  = diff;
    end
  end

endmodule

// File: rtl/smfx_mul.sv
module smfx_mul #(
  parameter int MAG_W  = 5,
  parameter int FRAC_W = 4
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             r_sign,
  output logic [MAG_W-1:0] r_mag
);

  localparam int PW = 2 * MAG_W;
  localparam int SW = PW - FRAC_W;

  logic [PW-1:0] prod;
  logic [SW-1:0] scaled;
  logic          over;

  assign prod   = a_mag * b_mag;
  assign scaled = prod[PW-1:FRAC_W];
  assign over   = |scaled[SW-1:MAG_W];
  assign r_sign = a_sign ^ b_sign;
  assign r_mag  = over ? {MAG_W{1'b1}} : scaled[MAG_W-1:0];

endmodule

// File: rtl/smfx_arith.sv
module smfx_arith
  import smfx_pkg::*;
#(
  parameter int INT_W  = 1,
  parameter int FRAC_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic                        s_op,
  input  logic [INT_W+FRAC_W:0]       s_a,
  input  logic [INT_W+FRAC_W:0]       s_b,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic [INT_W+FRAC_W:0]       m_data
);

  localparam int MAG_W = INT_W + FRAC_W;
  localparam int W     = MAG_W + 1;

  logic             add_sign, mul_sign, sel_sign;
  logic [MAG_W-1:0] add_mag, mul_mag, sel_mag;
  logic             take;

  smfx_addsub #(.MAG_W(MAG_W)) u_add (
    .a_sign(s_a[W-1]), .a_mag(s_a[MAG_W-1:0]),
    .b_sign(s_b[W-1]), .b_mag(s_b[MAG_W-1:0]),
    .r_sign(add_sign), .r_mag(add_mag)
  );

  smfx_mul #(.MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_mul (
    .a_sign(s_a[W-1]), .a_mag(s_a[MAG_W-1:0]),
    .b_sign(s_b[W-1]), .b_mag(s_b[MAG_W-1:0]),
    .r_sign(mul_sign), .r_mag(mul_mag)
  );

  always_comb begin
    if (s_op == SMFX_MUL) begin
      sel_mag  = mul_mag;
      sel_sign = mul_sign;
    end else begin
      sel_mag  = add_mag;
      sel_sign = add_sign;
    end
  end

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= {sel_sign & (|sel_mag), sel_mag};
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> m_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r7_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !(m_data[W-1] && (m_data[MAG_W-1:0] == '0)));

  a_r2_same_sign_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (take && s_op == SMFX_ADD && s_a[W-1] == s_b[W-1])
      |=> (m_data[W-1] == $past(s_a[W-1])) || (m_data[MAG_W-1:0] == '0));

  a_r4_sum_not_below: assert property (@(posedge clk) disable iff (!rst_n)
    (take && s_op == SMFX_ADD && s_a[W-1] == s_b[W-1])
      |=> (m_data[MAG_W-1:0] >= $past(s_a[MAG_W-1:0])));

  a_r5_mul_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (take && s_op == SMFX_MUL)
      |=> (m_data[W-1] == ($past(s_a[W-1]) ^ $past(s_b[W-1]))) ||
          (m_data[MAG_W-1:0] == '0));

endmodule

// File: tb/sim_smfx_arith.sv
`timescale 1ns/1ps
module sim_smfx_arith;

  typedef struct {
    logic [5:0] data;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic       s_op = 1'b0;
  logic [5:0] s_a = '0, s_b = '0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [5:0] m_data;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   bp_en = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  smfx_arith u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_op(s_op), .s_a(s_a), .s_b(s_b), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 m_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  function automatic exp_t model(input logic op, input logic [5:0] a,
                                 input logic [5:0] b);
    int   am, bm, m;
    logic s;
    exp_t e;
    am = a[4:0];
    bm = b[4:0];
    if (op == 1'b0) begin
      if (a[5] == b[5]) begin
        m = am + bm; s = a[5]; e.tag = "R2";
        if (m > 31) begin m = 31; e.tag = "R4"; end
      end else if (am > bm) begin
        m = am - bm; s = a[5]; e.tag = "R3";
      end else begin
        m = bm - am; s = b[5]; e.tag = "R3";
      end
    end else begin
      m = (am * bm) / 16; s = a[5] ^ b[5]; e.tag = "R5";
      if (m > 31) begin m = 31; e.tag = "R6"; end
    end
    if (m == 0) begin s = 1'b0; e.tag = {e.tag, " R7"}; end
    e.data = {s, m[4:0]};
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input int act,
                       input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act[5:0], expv[5:0]);
    end
  endtask

  task automatic send(input logic op, input logic [5:0] a,
                      input logic [5:0] b);
    @(negedge clk);
    s_valid = 1'b1; s_op = op; s_a = a; s_b = b;
    while (!s_ready) @(negedge clk);
    exp_q.push_back(model(op, a, b));
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  // Scoreboard monitor: compares each word handed over to the consumer.
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected result", m_data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(m_data === e.data, e.tag, m_data, e.data);
      end
    end
  end

  // R9: a stalled result holds and input is refused.
  logic       hold_prev = 1'b0;
  logic [5:0] hold_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        check(m_valid === 1'b1 && m_data === hold_data, "R9 hold",
              m_data, hold_data);
      if (m_valid && !m_ready)
        check(s_ready === 1'b0, "R9 s_ready low", s_ready, 0);
      hold_prev = m_valid && !m_ready;
      hold_data = m_data;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(m_valid === 1'b0, "R10 m_valid in reset", m_valid, 0);
    check(s_ready === 1'b1, "R10 s_ready in reset", s_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid === 1'b0, "R10 m_valid after reset", m_valid, 0);

    // R1: +1.0 plus +0.5 is +1.5 = 0_1_1000
    send(1'b0, 6'b0_1_0000, 6'b0_0_1000);
    check(m_valid === 1'b1, "R8 latency add", m_valid, 1);
    check(m_data === 6'b0_1_1000, "R1 format", m_data, 6'b011000);
    // R7: negative zero operands give positive zero
    send(1'b0, 6'b1_00000, 6'b0_00000);
    send(1'b1, 6'b1_00101, 6'b0_00000);
    send(1'b0, 6'b1_00111, 6'b0_00111);
    // R4 / R6 saturation corners
    send(1'b0, 6'b1_11111, 6'b1_00001);
    send(1'b1, 6'b1_11111, 6'b0_11111);
    check(m_valid === 1'b1, "R8 latency mul", m_valid, 1);

    // Exhaustive add then multiply, back to back (R8 ordering)
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          send(op[0], a[5:0], b[5:0]);

    // Back-pressure run (R9)
    bp_en = 1'b1;
    for (int i = 0; i < 600; i++)
      send(i[0], 6'((i * 37) % 64), 6'((i * 11 + 5) % 64));
    bp_en = 1'b0;

    for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule